// File: doc/BRIEF.md
# DRAM Clock Rate Change Sequencer

This block sits on the controller side of a DDR3-class memory interface. It moves the attached device from one stable clock rate to another. It accepts a single request that carries a target frequency code, a choice of low-power state (precharge power-down or self-refresh) and the mode-register images that suit the new rate. It then steps the device through the only window in which the clock may be changed:

1. Enter the low-power state with CKE low.
2. Wait the entry guard time.
3. Enable the external clock generator's switch and wait for its acknowledge.
4. Wait for the new clock to settle.
5. Exit the low-power state.
6. Reset the DLL through a mode-register write, rewrite the latency register, and wait for the DLL to relock.

Each wait is programmed from a timing input in clock cycles. One loadable down-counter serves all of them.

A request is checked before anything starts. The block refuses it if it arrives while a change is already running, or while any bank is still open. It also refuses a target code outside the supported operating range, and flags that this case needs the DLL-off procedure instead. The request fields are captured when the request is accepted. The caller may change them afterwards without effect.

Top module: `dram_fchg_seq`

## Requirements
- R1: While idle and out of reset: `cke`=1, `odt` equals `odt_req`, `clk_sw_en`=0, `cmd`=NOP (0), and `busy`, `done`, `illegal` and `dll_off_needed` are all 0.
- R2: A request is accepted when all of these hold at a clock edge: `req_valid`=1, the block is idle, `banks_closed`=1, and `req_freq` is within [FREQ_MIN, FREQ_MAX]. In the next cycle `busy`=1 and `cke`=0, and `cmd` is power-down entry (2) if `req_use_sr`=0, or self-refresh entry (4) if `req_use_sr`=1.
- R3: A request made while `busy`=1 or while `banks_closed`=0 gives a one-cycle `illegal` pulse in the next cycle. It does not start or disturb a sequence.
- R4: A request that would otherwise be accepted, but whose `req_freq` is below FREQ_MIN or above FREQ_MAX, gives a one-cycle `dll_off_needed` pulse in the next cycle. No sequence starts and `busy` stays 0.
- R5: `clk_sw_en` rises exactly `t_cksre`+2 cycles after the entry cycle. While it is high, `clk_freq` shows the accepted target code.
- R6: `clk_sw_en` stays high until the cycle in which `clk_sw_ack`=1. From entry until exit, `cke` and `odt` stay 0.
- R7: The exit command (power-down exit 3, or self-refresh exit 5) appears with `cke`=1 exactly `t_cksrx`+2 cycles after the cycle in which `clk_sw_en` and `clk_sw_ack` were both 1. By then `clk_sw_en` is 0.
- R8: `t_xp`+2 cycles after the exit cycle, `cmd` is MRS (1) with `cmd_ba`=0 and `cmd_addr` equal to the captured MR0 image with bit DLL_RST_BIT (8) set.
- R9: `t_mod`+2 cycles after the DLL reset command, `cmd` is MRS with `cmd_ba`=2 and `cmd_addr` equal to the captured MR2 image. `cke` stays 1 from exit until `done`.
- R10: `done` pulses exactly `t_mod`+`t_dllk`+3 cycles after the MR2 command. In the following cycle `busy`=0.
- R11: `odt` is 0 for every cycle in which `busy`=1, whatever the level of `odt_req`.
- R12: The target code and both mode-register images are captured at acceptance. Changing `req_freq`, `mr0_val` or `mr2_val` during a sequence has no effect on `clk_freq` or `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Frequency change request |
| req_freq | input | FW | Target frequency code |
| req_use_sr | input | 1 | 1: use self-refresh, 0: use precharge power-down |
| banks_closed | input | 1 | All banks are precharged |
| odt_req | input | 1 | ODT level wanted by the scheduler when idle |
| mr0_val | input | AW | MR0 image for the new rate (write recovery, CAS latency) |
| mr2_val | input | AW | MR2 image for the new rate (CAS write latency) |
| t_cksre | input | CW | Entry guard wait in cycles |
| t_cksrx | input | CW | New-clock settle wait in cycles |
| t_xp | input | CW | Exit-to-command wait in cycles |
| t_mod | input | CW | Mode-register command spacing in cycles |
| t_dllk | input | CW | DLL relock wait in cycles |
| clk_sw_ack | input | 1 | Clock generator has switched |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control |
| cmd | output | 3 | Command code: 0 NOP, 1 MRS, 2 PD entry, 3 PD exit, 4 SR entry, 5 SR exit |
| cmd_ba | output | 2 | Mode register select for MRS |
| cmd_addr | output | AW | Mode register value for MRS |
| clk_sw_en | output | 1 | Clock switch enable to the generator |
| clk_freq | output | FW | Target code to the generator |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle pulse when the device is ready at the new rate |
| illegal | output | 1 | One-cycle pulse: request refused because of state |
| dll_off_needed | output | 1 | One-cycle pulse: target out of range |

## Verification
The hardest case to reach is a request that arrives while a sequence is already running. It must be refused without affecting the run in progress. The stimulus holds `req_valid` high for a second cycle, so that the repeat lands in the entry cycle. The scenario then still drives the clock acknowledge and checks that the run completes. The clock switch wait is exercised by delaying the acknowledge by several cycles. During that delay the bench checks that the enable holds and that CKE and ODT stay low. The capture rule is tested by scrambling all request fields right after acceptance. Every timing relation is measured once with non-zero waits and once with all waits at zero.

// File: rtl/dram_fchg_pkg.sv
package dram_fchg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ENTER,
      ST_WAIT_CKSRE,
      ST_SWITCH,
      ST_WAIT_CKSRX,
      ST_EXIT,
      ST_WAIT_XP,
      ST_DLL_RESET,
      ST_MOD_GAP_A,
      ST_MRS_UPDATE,
      ST_MOD_GAP_B,
      ST_WAIT_LOCK,
      ST_DONE
   } seq_state_e;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_MRS = 3'd1,
      CMD_PDE = 3'd2,
      CMD_PDX = 3'd3,
      CMD_SRE = 3'd4,
      CMD_SRX = 3'd5
   } dram_cmd_e;

   localparam logic [1:0] MR_SEL_DLL = 2'd0;
   localparam logic [1:0] MR_SEL_CWL = 2'd2;

endpackage

// File: rtl/dram_fchg_timer.sv
module dram_fchg_timer #(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_fchg_admit.sv
module dram_fchg_admit #(
   parameter int FW       = 4,
   parameter int FREQ_MIN = 2,
   parameter int FREQ_MAX = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [FW-1:0] req_freq,
   input  logic          banks_closed,
   input  logic          seq_idle,
   output logic          accept,
   output logic          illegal_q,
   output logic          dll_off_q
);

   localparam logic [FW-1:0] LO_CODE = FW'(FREQ_MIN);
   localparam logic [FW-1:0] HI_CODE = FW'(FREQ_MAX);
   localparam int            TOP_CODE = (1 << FW) - 1;

   logic lo_ok;
   logic hi_ok;
   logic state_ok;
   logic in_range;

   generate
      if (FREQ_MIN == 0) begin : g_lo_open
         assign lo_ok = 1'b1;
      end else begin : g_lo_cmp
         assign lo_ok = (req_freq >= LO_CODE);
      end
      if (FREQ_MAX == TOP_CODE) begin : g_hi_open
         assign hi_ok = 1'b1;
      end else begin : g_hi_cmp
         assign hi_ok = (req_freq <= HI_CODE);
      end
   endgenerate

   assign in_range = lo_ok & hi_ok;
   assign state_ok = seq_idle & banks_closed;
   assign accept   = req_valid & state_ok & in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         illegal_q <= 1'b0;
         dll_off_q <= 1'b0;
      end else begin
         illegal_q <= req_valid & ~state_ok;
         dll_off_q <= req_valid & state_ok & ~in_range;
      end
   end

endmodule

// File: rtl/dram_fchg_fsm.sv
module dram_fchg_fsm
   import dram_fchg_pkg::*;
#(
   parameter int FW          = 4,
   parameter int CW          = 10,
   parameter int AW          = 14,
   parameter int DLL_RST_BIT = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [FW-1:0] req_freq,
   input  logic          req_use_sr,
   input  logic [AW-1:0] mr0_val,
   input  logic [AW-1:0] mr2_val,
   input  logic          odt_req,
   input  logic [CW-1:0] t_cksre,
   input  logic [CW-1:0] t_cksrx,
   input  logic [CW-1:0] t_xp,
   input  logic [CW-1:0] t_mod,
   input  logic [CW-1:0] t_dllk,
   input  logic          clk_sw_ack,
   input  logic          tmr_expired,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output logic          cke,
   output logic          odt,
   output logic [2:0]    cmd,
   output logic [1:0]    cmd_ba,
   output logic [AW-1:0] cmd_addr,
   output logic          clk_sw_en,
   output logic [FW-1:0] clk_freq,
   output logic          busy,
   output logic          done,
   output logic          seq_idle
);

   localparam logic [AW-1:0] DLL_RST_MASK = AW'(1) << DLL_RST_BIT;

   seq_state_e    st_q, st_d;
   logic [FW-1:0] freq_q;
   logic          sr_q;
   logic [AW-1:0] mr0_q;
   logic [AW-1:0] mr2_q;
   dram_cmd_e     cmd_e;

   // capture request fields at acceptance
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freq_q <= '0;
         sr_q   <= 1'b0;
         mr0_q  <= '0;
         mr2_q  <= '0;
      end else if (accept) begin
         freq_q <= req_freq;
         sr_q   <= req_use_sr;
         mr0_q  <= mr0_val;
         mr2_q  <= mr2_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // next state and timer loads
   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         ST_IDLE:       if (accept) st_d = ST_ENTER;
         ST_ENTER: begin
            tmr_load = 1'b1;
            tmr_val  = t_cksre;
            st_d     = ST_WAIT_CKSRE;
         end
         ST_WAIT_CKSRE: if (tmr_expired) st_d = ST_SWITCH;
         ST_SWITCH: begin
            if (clk_sw_ack) begin
               tmr_load = 1'b1;
               tmr_val  = t_cksrx;
               st_d     = ST_WAIT_CKSRX;
            end
         end
         ST_WAIT_CKSRX: if (tmr_expired) st_d = ST_EXIT;
         ST_EXIT: begin
            tmr_load = 1'b1;
            tmr_val  = t_xp;
            st_d     = ST_WAIT_XP;
         end
         ST_WAIT_XP:    if (tmr_expired) st_d = ST_DLL_RESET;
         ST_DLL_RESET: begin
            tmr_load = 1'b1;
            tmr_val  = t_mod;
            st_d     = ST_MOD_GAP_A;
         end
         ST_MOD_GAP_A:  if (tmr_expired) st_d = ST_MRS_UPDATE;
         ST_MRS_UPDATE: begin
            tmr_load = 1'b1;
            tmr_val  = t_mod;
            st_d     = ST_MOD_GAP_B;
         end
         ST_MOD_GAP_B: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               tmr_val  = t_dllk;
               st_d     = ST_WAIT_LOCK;
            end
         end
         ST_WAIT_LOCK:  if (tmr_expired) st_d = ST_DONE;
         ST_DONE:       st_d = ST_IDLE;
         default:       st_d = ST_IDLE;
      endcase
   end

   // pin levels and commands decoded from state
   always_comb begin
      cke       = 1'b1;
      odt       = 1'b0;
      cmd_e     = CMD_NOP;
      cmd_ba    = '0;
      cmd_addr  = '0;
      clk_sw_en = 1'b0;
      done      = 1'b0;
      unique case (st_q)
         ST_IDLE:  odt = odt_req;
         ST_ENTER: begin
            cke   = 1'b0;
            cmd_e = sr_q ? CMD_SRE : CMD_PDE;
         end
         ST_WAIT_CKSRE, ST_WAIT_CKSRX: cke = 1'b0;
         ST_SWITCH: begin
            cke       = 1'b0;
            clk_sw_en = 1'b1;
         end
         ST_EXIT:  cmd_e = sr_q ? CMD_SRX : CMD_PDX;
         ST_DLL_RESET: begin
            cmd_e    = CMD_MRS;
            cmd_ba   = MR_SEL_DLL;
            cmd_addr = mr0_q | DLL_RST_MASK;
         end
         ST_MRS_UPDATE: begin
            cmd_e    = CMD_MRS;
            cmd_ba   = MR_SEL_CWL;
            cmd_addr = mr2_q;
         end
         ST_DONE:  done = 1'b1;
         default:  ;
      endcase
   end

   assign cmd      = cmd_e;
   assign clk_freq = freq_q;
   assign seq_idle = (st_q == ST_IDLE);
   assign busy     = ~seq_idle;

endmodule

// File: rtl/dram_fchg_seq.sv
module dram_fchg_seq #(
   parameter int FW          = 4,
   parameter int CW          = 10,
   parameter int AW          = 14,
   parameter int FREQ_MIN    = 2,
   parameter int FREQ_MAX    = 9,
   parameter int DLL_RST_BIT = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [FW-1:0] req_freq,
   input  logic          req_use_sr,
   input  logic          banks_closed,
   input  logic          odt_req,
   input  logic [AW-1:0] mr0_val,
   input  logic [AW-1:0] mr2_val,
   input  logic [CW-1:0] t_cksre,
   input  logic [CW-1:0] t_cksrx,
   input  logic [CW-1:0] t_xp,
   input  logic [CW-1:0] t_mod,
   input  logic [CW-1:0] t_dllk,
   input  logic          clk_sw_ack,
   output logic          cke,
   output logic          odt,
   output logic [2:0]    cmd,
   output logic [1:0]    cmd_ba,
   output logic [AW-1:0] cmd_addr,
   output logic          clk_sw_en,
   output logic [FW-1:0] clk_freq,
   output logic          busy,
   output logic          done,
   output logic          illegal,
   output logic          dll_off_needed
);

   generate
      if (FREQ_MIN > FREQ_MAX) begin : g_bad_range
         $error("FREQ_MIN must not exceed FREQ_MAX");
      end
      if (FREQ_MAX >= (1 << FW)) begin : g_bad_code
         $error("FREQ_MAX does not fit in FW bits");
      end
      if (DLL_RST_BIT >= AW) begin : g_bad_bit
         $error("DLL_RST_BIT lies outside the address width");
      end
      if (CW < 1) begin : g_bad_cw
         $error("CW must be at least 1");
      end
   endgenerate

   logic          accept;
   logic          seq_idle;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_expired;

   dram_fchg_admit #(
      .FW       (FW),
      .FREQ_MIN (FREQ_MIN),
      .FREQ_MAX (FREQ_MAX)
   ) i_admit (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_freq     (req_freq),
      .banks_closed (banks_closed),
      .seq_idle     (seq_idle),
      .accept       (accept),
      .illegal_q    (illegal),
      .dll_off_q    (dll_off_needed)
   );

   dram_fchg_timer #(
      .CW (CW)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   dram_fchg_fsm #(
      .FW          (FW),
      .CW          (CW),
      .AW          (AW),
      .DLL_RST_BIT (DLL_RST_BIT)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .req_freq    (req_freq),
      .req_use_sr  (req_use_sr),
      .mr0_val     (mr0_val),
      .mr2_val     (mr2_val),
      .odt_req     (odt_req),
      .t_cksre     (t_cksre),
      .t_cksrx     (t_cksrx),
      .t_xp        (t_xp),
      .t_mod       (t_mod),
      .t_dllk      (t_dllk),
      .clk_sw_ack  (clk_sw_ack),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .cke         (cke),
      .odt         (odt),
      .cmd         (cmd),
      .cmd_ba      (cmd_ba),
      .cmd_addr    (cmd_addr),
      .clk_sw_en   (clk_sw_en),
      .clk_freq    (clk_freq),
      .busy        (busy),
      .done        (done),
      .seq_idle    (seq_idle)
   );

endmodule

// File: rtl/dram_fchg_chk.sv
module dram_fchg_chk #(
   parameter int FW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          cke,
   input logic          odt,
   input logic [2:0]    cmd,
   input logic          clk_sw_en,
   input logic [FW-1:0] clk_freq,
   input logic          busy,
   input logic          done,
   input logic          illegal,
   input logic          dll_off_needed
);

   // R6
   sw_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sw_en |-> (!cke && !odt));

   // R5
   sw_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_sw_en) |-> $past(!cke));

   // R9
   mrs_cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1) |-> cke);

   // R11
   odt_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !odt);

   // R10
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R3
   illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $past(req_valid));

   // R4
   dll_off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dll_off_needed |-> (!busy && $past(req_valid)));

   // R12
   freq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(clk_freq));

   // R2
   entry_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 3'd2) || (cmd == 3'd4)) |-> (!cke && $past(!busy)));

endmodule

bind dram_fchg_seq dram_fchg_chk #(
   .FW (FW)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .cke            (cke),
   .odt            (odt),
   .cmd            (cmd),
   .clk_sw_en      (clk_sw_en),
   .clk_freq       (clk_freq),
   .busy           (busy),
   .done           (done),
   .illegal        (illegal),
   .dll_off_needed (dll_off_needed)
);

// File: tb/test_dram_fchg_seq.sv
`timescale 1ns/100ps
module test_dram_fchg_seq;

   localparam int FW = 4;
   localparam int CW = 10;
   localparam int AW = 14;
   localparam int LIM = 4000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [FW-1:0] req_freq = '0;
   logic          req_use_sr = 1'b0;
   logic          banks_closed = 1'b1;
   logic          odt_req = 1'b1;
   logic [AW-1:0] mr0_val = '0;
   logic [AW-1:0] mr2_val = '0;
   logic [CW-1:0] t_cksre = '0;
   logic [CW-1:0] t_cksrx = '0;
   logic [CW-1:0] t_xp = '0;
   logic [CW-1:0] t_mod = '0;
   logic [CW-1:0] t_dllk = '0;
   logic          clk_sw_ack = 1'b0;
   logic          cke;
   logic          odt;
   logic [2:0]    cmd;
   logic [1:0]    cmd_ba;
   logic [AW-1:0] cmd_addr;
   logic          clk_sw_en;
   logic [FW-1:0] clk_freq;
   logic          busy;
   logic          done;
   logic          illegal;
   logic          dll_off_needed;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   dram_fchg_seq i_dram_fchg_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq(req_freq),
      .req_use_sr(req_use_sr), .banks_closed(banks_closed), .odt_req(odt_req),
      .mr0_val(mr0_val), .mr2_val(mr2_val), .t_cksre(t_cksre), .t_cksrx(t_cksrx),
      .t_xp(t_xp), .t_mod(t_mod), .t_dllk(t_dllk), .clk_sw_ack(clk_sw_ack),
      .cke(cke), .odt(odt), .cmd(cmd), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
      .clk_sw_en(clk_sw_en), .clk_freq(clk_freq), .busy(busy), .done(done),
      .illegal(illegal), .dll_off_needed(dll_off_needed)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic check_idle(input string req);
      chk(cke == 1'b1, req, "cke idle", cke, 1);
      chk(odt == odt_req, req, "odt follows odt_req", odt, odt_req);
      chk(clk_sw_en == 1'b0, req, "clk_sw_en idle", clk_sw_en, 0);
      chk(cmd == 3'd0, req, "cmd idle", cmd, 0);
      chk({busy, done, illegal, dll_off_needed} == 4'b0, req, "flags idle",
          {busy, done, illegal, dll_off_needed}, 0);
   endtask

   // R1
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");
      odt_req = 1'b0;
      @(negedge clk);
      chk(odt == 1'b0, "R1", "odt follows low odt_req", odt, 0);
      odt_req = 1'b1;
   endtask

   task automatic run_seq(input bit sr, input logic [FW-1:0] f,
                          input logic [AW-1:0] m0, input logic [AW-1:0] m2,
                          input int ack_dly, input int tcs, input int tcx,
                          input int txp, input int tmd, input int tdl);
      int c;
      bit bad;
      logic [AW-1:0] exp0;
      exp0 = m0 | (AW'(1) << 8);
      t_cksre = CW'(tcs); t_cksrx = CW'(tcx); t_xp = CW'(txp);
      t_mod = CW'(tmd); t_dllk = CW'(tdl);
      odt_req = 1'b1; banks_closed = 1'b1; clk_sw_ack = 1'b0;
      req_valid = 1'b1; req_freq = f; req_use_sr = sr; mr0_val = m0; mr2_val = m2;
      @(negedge clk);
      // R12: scramble request fields right after acceptance
      req_valid = 1'b0; req_freq = ~f; req_use_sr = ~sr; mr0_val = ~m0; mr2_val = ~m2;
      chk(busy && !cke, "R2", "entry busy/cke", {busy, cke}, 2'b10);
      chk(cmd == (sr ? 3'd4 : 3'd2), "R2", "entry command", cmd, sr ? 4 : 2);
      chk(odt == 1'b0, "R11", "odt low at entry", odt, 0);
      c = 0; bad = 0;
      do begin
         @(negedge clk); c++;
         if (cke || odt) bad = 1;
      end while (!clk_sw_en && c < LIM);
      chk(c == tcs + 2, "R5", "cycles entry to switch", c, tcs + 2);
      chk(clk_freq == f, "R12", "clk_freq target", clk_freq, f);
      for (int k = 0; k < ack_dly; k++) begin
         @(negedge clk);
         if (!clk_sw_en || cke || odt) bad = 1;
      end
      chk(!bad, "R6", "switch hold with cke/odt low", bad, 0);
      clk_sw_ack = 1'b1;
      c = 0;
      do begin
         @(negedge clk); c++;
         if (c == 1) clk_sw_ack = 1'b0;
      end while (!cke && c < LIM);
      chk(c == tcx + 2, "R7", "cycles ack to exit", c, tcx + 2);
      chk(cmd == (sr ? 3'd5 : 3'd3), "R7", "exit command", cmd, sr ? 5 : 3);
      chk(!clk_sw_en, "R7", "switch released", clk_sw_en, 0);
      c = 0; bad = 0;
      do begin
         @(negedge clk); c++;
         if (!cke || odt) bad = 1;
      end while (cmd != 3'd1 && c < LIM);
      chk(c == txp + 2, "R8", "cycles exit to DLL reset", c, txp + 2);
      chk(cmd_ba == 2'd0, "R8", "DLL reset register", cmd_ba, 0);
      chk(cmd_addr == exp0, "R8", "DLL reset value", cmd_addr, exp0);
      c = 0;
      do begin
         @(negedge clk); c++;
         if (!cke || odt) bad = 1;
      end while (cmd != 3'd1 && c < LIM);
      chk(c == tmd + 2, "R9", "cycles to MR2 write", c, tmd + 2);
      chk(cmd_ba == 2'd2, "R9", "MR2 register", cmd_ba, 2);
      chk(cmd_addr == m2, "R12", "MR2 value captured", cmd_addr, m2);
      c = 0;
      do begin
         @(negedge clk); c++;
         if (!cke || odt) bad = 1;
      end while (!done && c < LIM);
      chk(c == tmd + tdl + 3, "R10", "cycles to done", c, tmd + tdl + 3);
      chk(!bad, "R9", "cke high, odt low after exit", bad, 0);
      @(negedge clk);
      chk(!busy && !done, "R10", "idle after done", {busy, done}, 0);
      chk(odt == odt_req, "R11", "odt restored", odt, odt_req);
   endtask

   // R3
   task automatic t_reject_banks();
      banks_closed = 1'b0; req_valid = 1'b1; req_freq = 4'd5;
      @(negedge clk);
      req_valid = 1'b0;
      chk(illegal == 1'b1, "R3", "illegal with open banks", illegal, 1);
      chk(!busy && cke, "R3", "no start with open banks", {busy, cke}, 2'b01);
      @(negedge clk);
      chk(illegal == 1'b0, "R3", "illegal is one pulse", illegal, 0);
      banks_closed = 1'b1;
   endtask

   // R3
   task automatic t_reject_busy();
      int c;
      t_cksre = 2; t_cksrx = 2; t_xp = 2; t_mod = 2; t_dllk = 4;
      clk_sw_ack = 1'b1; req_valid = 1'b1; req_freq = 4'd6; req_use_sr = 1'b0;
      @(negedge clk);
      req_freq = 4'd7;
      @(negedge clk);
      req_valid = 1'b0;
      chk(illegal == 1'b1, "R3", "illegal while busy", illegal, 1);
      chk(busy && clk_freq == 4'd6, "R3", "running sequence kept", clk_freq, 6);
      c = 0;
      while (busy && c < LIM) begin @(negedge clk); c++; end
      clk_sw_ack = 1'b0;
      chk(!busy && clk_freq == 4'd6, "R3", "sequence finished undisturbed", clk_freq, 6);
   endtask

   // R4
   task automatic t_range(input logic [FW-1:0] f);
      req_valid = 1'b1; req_freq = f;
      @(negedge clk);
      req_valid = 1'b0;
      chk(dll_off_needed == 1'b1, "R4", "dll_off flagged", dll_off_needed, 1);
      chk(!busy && !illegal && cke, "R4", "no start", {busy, illegal, cke}, 3'b001);
      @(negedge clk);
      chk(dll_off_needed == 1'b0 && !busy, "R4", "one pulse, still idle",
          {dll_off_needed, busy}, 0);
   endtask

   initial begin
      t_reset();
      run_seq(1'b0, 4'd2, 14'h0A31, 14'h0018, 3, 3, 5, 4, 6, 20);
      run_seq(1'b1, 4'd9, 14'h1C42, 14'h0020, 0, 0, 0, 0, 0, 0);
      t_reject_banks();
      t_reject_busy();
      t_range(4'd1);
      t_range(4'd12);
      check_idle("R1");
      report();
   end

   initial begin
      #(5 * 100000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

endmodule